// File: doc/BRIEF.md
# Hardwired Timing and Instruction Sequencer

This block is the control unit of a small accumulator machine with a 16-bit instruction word. It has a 4-bit step counter whose value is decoded into sixteen one-hot timing terms. It also registers the opcode field, decodes it into eight one-hot lines, and captures the indirect flag. The timing terms are ANDed with the opcode lines to produce the bus select code and the load, increment, read and write strobes for an external datapath. That datapath holds PC, AR, IR, DR, AC and the E carry bit, and it returns the status bits the sequencer needs.

Every instruction follows the same path: a fetch, a decode step, and an optional indirect address read. The sequencer then runs one of seven memory-reference sequences, or it gives a single register-reference step to the datapath. Each sequence ends by clearing the step counter, so the next fetch starts at step 0. A run flag gates the whole unit. `start_i` sets the flag. A halt bit in a register-reference instruction clears it. While the flag is low, the counter holds and no strobe is driven.

The datapath provides the IR bits [15:12] (indirect flag and opcode) and [4:0] (register-reference skip and halt selects). It also drives AC zero, AC sign, E and DR zero from its own registers.

Top module: `hw_sequencer`

## Requirements
- R1: After reset, step_o is 0, running_o is 0 and every strobe, bus_sel_o and alu_op_o are 0.
- R2: A high start_i while stopped sets running_o on the next edge. While running_o is 0, step_o holds and bus_sel_o, alu_op_o and all strobes are 0.
- R3: At step 0 the unit drives bus_sel_o=2 (PC) with ar_ld_o. At step 1 it drives bus_sel_o=7 (memory) with mem_rd_o, ir_ld_o and pc_inc_o.
- R4: At step 2 the unit drives bus_sel_o=5 (IR) with ar_ld_o. On that edge it registers opcode ir_hi_i[2:0] and indirect flag ir_hi_i[3].
- R5: At step 3, for opcodes 0 to 6: if the flag is 1, the unit drives bus_sel_o=7 with mem_rd_o and ar_ld_o. If the flag is 0, it drives nothing and the next step is 4.
- R6: Opcodes 0 (AND), 1 (ADD) and 2 (load) drive bus_sel_o=7, mem_rd_o and dr_ld_o at step 4. At step 5 they drive ac_ld_o with alu_op_o equal to 0, 1 or 2 respectively, and the next step is 0. alu_op_o is 0 whenever ac_ld_o is 0.
- R7: Opcode 3 (store) drives bus_sel_o=4 (AC) and mem_wr_o at step 4. Opcode 4 (jump) drives bus_sel_o=1 (AR) and pc_ld_o at step 4. For both, the next step is 0.
- R8: Opcode 5 (call) drives bus_sel_o=2, mem_wr_o and ar_inc_o at step 4. It drives bus_sel_o=1 and pc_ld_o at step 5, and the next step is 0.
- R9: Opcode 6 (increment-and-skip) reads into DR at step 4 and drives dr_inc_o at step 5. At step 6 it drives bus_sel_o=3 (DR) and mem_wr_o, with pc_inc_o equal to dr_zero_i. The next step is 0.
- R10: Opcode 7 with flag 0 drives rr_exec_o at step 3, and the next step is 0. At that step, pc_inc_o is the OR of four terms: ir_lo_i[4] and not AC sign; ir_lo_i[3] and AC sign; ir_lo_i[2] and AC zero; ir_lo_i[1] and not E.
- R11: When ir_lo_i[0] is 1 during a register-reference step, running_o falls on that edge and step_o returns to 0.
- R12: Opcode 7 with flag 1 drives no strobe at step 3, and the next step is 0.
- R13: mem_rd_o and mem_wr_o are never high together, and step_o never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sets the run flag when stopped |
| ir_hi_i | input | 4 | IR[15:12]: indirect flag in bit 3, opcode in bits 2:0 |
| ir_lo_i | input | 5 | IR[4:0]: skip selects in bits 4:1, halt in bit 0 |
| ac_zero_i | input | 1 | AC equals zero |
| ac_sign_i | input | 1 | AC bit 15 |
| e_i | input | 1 | Carry bit E |
| dr_zero_i | input | 1 | DR equals zero |
| bus_sel_o | output | 3 | Bus source: 0 none, 1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 6 TR, 7 memory |
| ir_ld_o | output | 1 | Load IR from bus |
| ar_ld_o | output | 1 | Load AR from bus |
| ar_inc_o | output | 1 | Increment AR |
| pc_ld_o | output | 1 | Load PC from bus |
| pc_inc_o | output | 1 | Increment PC |
| dr_ld_o | output | 1 | Load DR from bus |
| dr_inc_o | output | 1 | Increment DR |
| ac_ld_o | output | 1 | Load AC from ALU |
| alu_op_o | output | 2 | ALU function: 0 AND, 1 ADD, 2 pass DR |
| mem_rd_o | output | 1 | Memory read at AR |
| mem_wr_o | output | 1 | Memory write at AR |
| rr_exec_o | output | 1 | Register-reference execute step |
| running_o | output | 1 | Run flag |
| step_o | output | 4 | Current step counter value |

## Verification
In one register-reference step, a skip and a halt can both take effect: pc_inc_o must fire in the same cycle that sets up the fall of running_o. The bench provokes this with an instruction that sets the halt bit and the AC-zero skip select while ac_zero_i is high. It then expects pc_inc_o and rr_exec_o together at step 3, followed by running_o low with step_o at 0. The bench also requires the unit to stay silent for several cycles and to resume at a clean fetch after start_i. Separately, the increment-and-skip write step combines a memory write with a conditional PC increment. This case is swept with dr_zero_i at both values.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_AR   = 3'd1,
    BUS_PC   = 3'd2,
    BUS_DR   = 3'd3,
    BUS_AC   = 3'd4,
    BUS_IR   = 3'd5,
    BUS_TR   = 3'd6,
    BUS_MEM  = 3'd7
  } bus_sel_e;

  typedef enum logic [1:0] {
    ALU_AND  = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_PASS = 2'd2
  } alu_op_e;

  localparam int unsigned OPC_AND = 0;
  localparam int unsigned OPC_ADD = 1;
  localparam int unsigned OPC_LDA = 2;
  localparam int unsigned OPC_STA = 3;
  localparam int unsigned OPC_JMP = 4;
  localparam int unsigned OPC_CAL = 5;
  localparam int unsigned OPC_ISK = 6;
  localparam int unsigned OPC_REG = 7;

  typedef struct packed {
    bus_sel_e bus;
    logic     ir_ld;
    logic     ar_ld;
    logic     ar_inc;
    logic     pc_ld;
    logic     pc_inc;
    logic     dr_ld;
    logic     dr_inc;
    logic     ac_ld;
    alu_op_e  alu;
    logic     mem_rd;
    logic     mem_wr;
    logic     rr_exec;
    logic     seq_clr;
    logic     halt;
  } ctrl_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned NUM_T = 1 << CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NUM_T-1:0] t_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (run_i) begin
      if (clr_i)      cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_T; k++) begin : g_tdec
    assign t_o[k] = (cnt_q == CNT_W'(k));
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/seq_opdec.sv
module seq_opdec #(
  parameter int unsigned OPC_W = 3,
  localparam int unsigned NUM_D = 1 << OPC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [OPC_W:0]   ir_hi_i,
  output logic [NUM_D-1:0] d_o,
  output logic             ind_o
);
  logic [OPC_W-1:0] opc_q;
  logic             ind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= '0;
      ind_q <= 1'b0;
    end else if (cap_i) begin
      opc_q <= ir_hi_i[OPC_W-1:0];
      ind_q <= ir_hi_i[OPC_W];
    end
  end

  for (genvar k = 0; k < NUM_D; k++) begin : g_ddec
    assign d_o[k] = (opc_q == OPC_W'(k));
  end

  assign ind_o = ind_q;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned NUM_T = 16,
  parameter int unsigned NUM_D = 8,
  localparam int unsigned LAST_T = 6
) (
  input  logic             run_i,
  input  logic [NUM_T-1:0] t_i,
  input  logic [NUM_D-1:0] d_i,
  input  logic             ind_i,
  input  logic [4:0]       ir_lo_i,
  input  logic             ac_zero_i,
  input  logic             ac_sign_i,
  input  logic             e_i,
  input  logic             dr_zero_i,
  output ctrl_t            ctrl_o
);
  logic skip;
  logic late;

  assign skip = (ir_lo_i[4] & ~ac_sign_i) | (ir_lo_i[3] & ac_sign_i)
              | (ir_lo_i[2] & ac_zero_i)  | (ir_lo_i[1] & ~e_i);
  // any step past the last used one restarts the fetch
  assign late = |t_i[NUM_T-1:LAST_T+1];

  always_comb begin
    ctrl_o     = '0;
    ctrl_o.bus = BUS_NONE;
    ctrl_o.alu = ALU_AND;
    if (run_i) begin
      ctrl_o.seq_clr = late;
      if (t_i[0]) begin
        ctrl_o.bus   = BUS_PC;
        ctrl_o.ar_ld = 1'b1;
      end
      if (t_i[1]) begin
        ctrl_o.bus    = BUS_MEM;
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.ir_ld  = 1'b1;
        ctrl_o.pc_inc = 1'b1;
      end
      if (t_i[2]) begin
        ctrl_o.bus   = BUS_IR;
        ctrl_o.ar_ld = 1'b1;
      end
      if (t_i[3]) begin
        if (d_i[OPC_REG]) begin
          ctrl_o.seq_clr = 1'b1;
          if (!ind_i) begin
            ctrl_o.rr_exec = 1'b1;
            ctrl_o.pc_inc  = skip;
            ctrl_o.halt    = ir_lo_i[0];
          end
        end else if (ind_i) begin
          ctrl_o.bus    = BUS_MEM;
          ctrl_o.mem_rd = 1'b1;
          ctrl_o.ar_ld  = 1'b1;
        end
      end
      if (t_i[4]) begin
        if (d_i[OPC_AND] | d_i[OPC_ADD] | d_i[OPC_LDA] | d_i[OPC_ISK]) begin
          ctrl_o.bus    = BUS_MEM;
          ctrl_o.mem_rd = 1'b1;
          ctrl_o.dr_ld  = 1'b1;
        end
        if (d_i[OPC_STA]) begin
          ctrl_o.bus     = BUS_AC;
          ctrl_o.mem_wr  = 1'b1;
          ctrl_o.seq_clr = 1'b1;
        end
        if (d_i[OPC_JMP]) begin
          ctrl_o.bus     = BUS_AR;
          ctrl_o.pc_ld   = 1'b1;
          ctrl_o.seq_clr = 1'b1;
        end
        if (d_i[OPC_CAL]) begin
          ctrl_o.bus    = BUS_PC;
          ctrl_o.mem_wr = 1'b1;
          ctrl_o.ar_inc = 1'b1;
        end
      end
      if (t_i[5]) begin
        if (d_i[OPC_AND] | d_i[OPC_ADD] | d_i[OPC_LDA]) begin
          ctrl_o.ac_ld   = 1'b1;
          ctrl_o.seq_clr = 1'b1;
          ctrl_o.alu     = d_i[OPC_ADD] ? ALU_ADD : (d_i[OPC_LDA] ? ALU_PASS : ALU_AND);
        end
        if (d_i[OPC_CAL]) begin
          ctrl_o.bus     = BUS_AR;
          ctrl_o.pc_ld   = 1'b1;
          ctrl_o.seq_clr = 1'b1;
        end
        if (d_i[OPC_ISK]) ctrl_o.dr_inc = 1'b1;
      end
      if (t_i[LAST_T] && d_i[OPC_ISK]) begin
        ctrl_o.bus     = BUS_DR;
        ctrl_o.mem_wr  = 1'b1;
        ctrl_o.pc_inc  = dr_zero_i;
        ctrl_o.seq_clr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hw_sequencer.sv
module hw_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned OPC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OPC_W:0]   ir_hi_i,
  input  logic [4:0]       ir_lo_i,
  input  logic             ac_zero_i,
  input  logic             ac_sign_i,
  input  logic             e_i,
  input  logic             dr_zero_i,
  output logic [2:0]       bus_sel_o,
  output logic             ir_ld_o,
  output logic             ar_ld_o,
  output logic             ar_inc_o,
  output logic             pc_ld_o,
  output logic             pc_inc_o,
  output logic             dr_ld_o,
  output logic             dr_inc_o,
  output logic             ac_ld_o,
  output logic [1:0]       alu_op_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             rr_exec_o,
  output logic             running_o,
  output logic [CNT_W-1:0] step_o
);
  localparam int unsigned NUM_T = 1 << CNT_W;
  localparam int unsigned NUM_D = 1 << OPC_W;

  logic             run_q;
  logic [NUM_T-1:0] t_vec;
  logic [NUM_D-1:0] d_vec;
  logic             ind;
  ctrl_t            ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= 1'b0;
    else if (run_q && ctrl.halt)  run_q <= 1'b0;
    else if (start_i)             run_q <= 1'b1;
  end

  seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .clr_i (ctrl.seq_clr),
    .cnt_o (step_o),
    .t_o   (t_vec)
  );

  seq_opdec #(.OPC_W(OPC_W)) u_opdec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (run_q & t_vec[2]),
    .ir_hi_i(ir_hi_i),
    .d_o    (d_vec),
    .ind_o  (ind)
  );

  seq_ctrl #(.NUM_T(NUM_T), .NUM_D(NUM_D)) u_ctrl (
    .run_i    (run_q),
    .t_i      (t_vec),
    .d_i      (d_vec),
    .ind_i    (ind),
    .ir_lo_i  (ir_lo_i),
    .ac_zero_i(ac_zero_i),
    .ac_sign_i(ac_sign_i),
    .e_i      (e_i),
    .dr_zero_i(dr_zero_i),
    .ctrl_o   (ctrl)
  );

  assign bus_sel_o = ctrl.bus;
  assign ir_ld_o   = ctrl.ir_ld;
  assign ar_ld_o   = ctrl.ar_ld;
  assign ar_inc_o  = ctrl.ar_inc;
  assign pc_ld_o   = ctrl.pc_ld;
  assign pc_inc_o  = ctrl.pc_inc;
  assign dr_ld_o   = ctrl.dr_ld;
  assign dr_inc_o  = ctrl.dr_inc;
  assign ac_ld_o   = ctrl.ac_ld;
  assign alu_op_o  = ctrl.alu;
  assign mem_rd_o  = ctrl.mem_rd;
  assign mem_wr_o  = ctrl.mem_wr;
  assign rr_exec_o = ctrl.rr_exec;
  assign running_o = run_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [4:0] ir_lo_i,
  input logic [2:0] bus_sel_o,
  input logic       ir_ld_o,
  input logic       ar_ld_o,
  input logic       pc_inc_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       rr_exec_o,
  input logic       running_o,
  input logic [3:0] step_o
);
  AST_T0_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && step_o == 4'd0) |-> (bus_sel_o == 3'd2 && ar_ld_o)); // R3
  AST_IR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_ld_o |-> (mem_rd_o && pc_inc_o && bus_sel_o == 3'd7)); // R3
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !start_i) |=> ($stable(step_o) && !running_o)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> (bus_sel_o == 3'd0 && !mem_rd_o && !mem_wr_o && !pc_inc_o && !ir_ld_o)); // R2
  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && bus_sel_o != 3'd2) |=> (step_o == 4'd0)); // R7
  AST_HALT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_exec_o && ir_lo_i[0]) |=> !running_o); // R11
  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R13
  AST_STEP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o <= 4'd6); // R13
endmodule

bind hw_sequencer seq_checker u_seq_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .ir_lo_i  (ir_lo_i),
  .bus_sel_o(bus_sel_o),
  .ir_ld_o  (ir_ld_o),
  .ar_ld_o  (ar_ld_o),
  .pc_inc_o (pc_inc_o),
  .mem_rd_o (mem_rd_o),
  .mem_wr_o (mem_wr_o),
  .rr_exec_o(rr_exec_o),
  .running_o(running_o),
  .step_o   (step_o)
);

// File: tb/tb_hw_sequencer.sv
`timescale 1ns/1ps
module tb_hw_sequencer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] ir_hi_i = '0;
  logic [4:0] ir_lo_i = '0;
  logic       ac_zero_i = 1'b0, ac_sign_i = 1'b0, e_i = 1'b0, dr_zero_i = 1'b0;
  logic [2:0] bus_sel_o;
  logic       ir_ld_o, ar_ld_o, ar_inc_o, pc_ld_o, pc_inc_o, dr_ld_o, dr_inc_o, ac_ld_o;
  logic [1:0] alu_op_o;
  logic       mem_rd_o, mem_wr_o, rr_exec_o, running_o;
  logic [3:0] step_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  hw_sequencer dut (
    .clk_i, .rst_ni, .start_i, .ir_hi_i, .ir_lo_i, .ac_zero_i, .ac_sign_i, .e_i, .dr_zero_i,
    .bus_sel_o, .ir_ld_o, .ar_ld_o, .ar_inc_o, .pc_ld_o, .pc_inc_o, .dr_ld_o, .dr_inc_o,
    .ac_ld_o, .alu_op_o, .mem_rd_o, .mem_wr_o, .rr_exec_o, .running_o, .step_o
  );

  function automatic logic [15:0] act_vec();
    return {bus_sel_o, ir_ld_o, ar_ld_o, ar_inc_o, pc_ld_o, pc_inc_o, dr_ld_o, dr_inc_o,
            ac_ld_o, alu_op_o, mem_rd_o, mem_wr_o, rr_exec_o};
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string req_of(input int s, input int opc, input bit ind);
    if (s < 2) return "R3";
    if (s == 2) return "R4";
    if (s == 3) return (opc == 7) ? (ind ? "R12" : "R10") : "R5";
    if (opc <= 2) return "R6";
    if (opc <= 4) return "R7";
    if (opc == 5) return "R8";
    return "R9";
  endfunction

  function automatic bit is_last(input int s, input int opc);
    return (s == 3 && opc == 7) || (s == 4 && (opc == 3 || opc == 4)) ||
           (s == 5 && (opc <= 2 || opc == 5)) || (s == 6 && opc == 6);
  endfunction

  function automatic logic [15:0] exp_vec(input int s, input int opc, input bit ind,
                                          input logic [4:0] lo, input bit az, input bit as,
                                          input bit ev, input bit dz);
    logic [2:0] bus;
    logic irl, arl, ari, pcl, pci, drl, dri, acl, rd, wr, rr;
    logic [1:0] alu;
    bus = 3'd0; alu = 2'd0;
    {irl, arl, ari, pcl, pci, drl, dri, acl, rd, wr, rr} = '0;
    case (s)
      0: begin bus = 3'd2; arl = 1; end
      1: begin bus = 3'd7; rd = 1; irl = 1; pci = 1; end
      2: begin bus = 3'd5; arl = 1; end
      3: if (opc == 7) begin
           if (!ind) begin
             rr = 1;
             pci = (lo[4] & ~as) | (lo[3] & as) | (lo[2] & az) | (lo[1] & ~ev);
           end
         end else if (ind) begin bus = 3'd7; rd = 1; arl = 1; end
      4: case (opc)
           0, 1, 2, 6: begin bus = 3'd7; rd = 1; drl = 1; end
           3: begin bus = 3'd4; wr = 1; end
           4: begin bus = 3'd1; pcl = 1; end
           5: begin bus = 3'd2; wr = 1; ari = 1; end
           default: ;
         endcase
      5: case (opc)
           0, 1, 2: begin acl = 1; alu = 2'(opc); end
           5: begin bus = 3'd1; pcl = 1; end
           6: dri = 1;
           default: ;
         endcase
      6: if (opc == 6) begin bus = 3'd3; wr = 1; pci = dz; end
      default: ;
    endcase
    return {bus, irl, arl, ari, pcl, pci, drl, dri, acl, alu, rd, wr, rr};
  endfunction

  // Called at 1 ns after a rising edge with step_o expected at 0.
  task automatic run_one(input int opc, input bit ind, input logic [4:0] lo, input bit az,
                         input bit as, input bit ev, input bit dz, input bit exp_run);
    ir_hi_i = {ind, 3'(opc)};
    ir_lo_i = lo;
    ac_zero_i = az; ac_sign_i = as; e_i = ev; dr_zero_i = dz;
    for (int s = 0; s < 7; s++) begin
      bit last;
      #1;
      chk(req_of(s, opc, ind), $sformatf("step op=%0d i=%0d", opc, ind), 16'(step_o), 16'(s));
      chk(req_of(s, opc, ind), $sformatf("strobes op=%0d i=%0d s=%0d", opc, ind, s),
          act_vec(), exp_vec(s, opc, ind, lo, az, as, ev, dz));
      last = is_last(s, opc);
      @(posedge clk_i);
      #1;
      if (last) break;
    end
    chk(exp_run ? req_of(4, opc, ind) : "R11", "restart step", 16'(step_o), 16'd0);
    chk(exp_run ? "R2" : "R11", "running after instr", 16'(running_o), 16'(exp_run));
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(posedge clk_i);
    #1;
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "reset step", 16'(step_o), 16'd0);
    chk("R1", "reset running", 16'(running_o), 16'd0);
    chk("R1", "reset strobes", act_vec(), 16'd0);
    // R2 stopped: holds, silent
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_i);
      #2;
      chk("R2", "stopped step", 16'(step_o), 16'd0);
      chk("R2", "stopped strobes", act_vec(), 16'd0);
    end
    @(posedge clk_i);
    #1;
    pulse_start();
    chk("R2", "start sets run", 16'(running_o), 16'd1);

    // sweep every opcode and flag, both DR-zero values
    for (int opc = 0; opc < 8; opc++)
      for (int ind = 0; ind < 2; ind++)
        for (int dz = 0; dz < 2; dz++)
          run_one(opc, 1'(ind), 5'd0, 1'b0, 1'b0, 1'b1, 1'(dz), 1'b1);

    // register-reference skips: all select patterns against all status values
    for (int sel = 0; sel < 16; sel++)
      for (int fl = 0; fl < 8; fl++)
        run_one(7, 1'b0, {4'(sel), 1'b0}, fl[0], fl[1], fl[2], 1'b0, 1'b1);

    // R11 halt together with an AC-zero skip in the same step
    run_one(7, 1'b0, 5'b00101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk_i);
      #2;
      chk("R2", "halted step", 16'(step_o), 16'd0);
      chk("R2", "halted strobes", act_vec(), 16'd0);
      chk("R11", "halted running", 16'(running_o), 16'd0);
    end
    @(posedge clk_i);
    #1;
    pulse_start();
    chk("R2", "restart run", 16'(running_o), 16'd1);
    run_one(1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_one(6, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    finish_run();
  end
endmodule